// File: doc/BRIEF.md
# Control-Word Register/ALU/Memory Datapath

This block is a single-cycle datapath steered entirely by a control word supplied each clock. It holds a register file with two combinational read ports and one clocked write port. It also holds an arithmetic/logic unit that reports four status flags, and a word-addressed RAM. A selector picks the second ALU operand: either a register or an immediate constant. A second selector picks what is written back: either the ALU output or the RAM read data. No instruction decoding or program sequencing happens inside. An external controller drives the select fields, write enables and operation code directly.

The RAM address is always the value read on the first register port. An absolute address must therefore be placed in a register first. Store data always comes from the second operand path, so a constant can be written straight into memory. An operation code that forwards the second operand unchanged lets a constant be loaded into a register. The block carries no data stream, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `cw_datapath`

## Requirements
- R1: While `rst_n` is low and after it is released, every register in the register file reads as zero until it is written.
- R2: The register selected by `dst_sel` takes the write-back value on the rising clock edge, and only when `reg_we` is 1. A register read in the same cycle it is written returns its old value.
- R3: The first ALU operand is the register selected by `srca_sel`. The second is the register selected by `srcb_sel` when `imm_sel` is 0, and `imm` when `imm_sel` is 1.
- R4: When `mem_we` is 1, the second-operand value is written on the rising edge into the RAM word addressed by the low 8 bits of the first operand. RAM reads are combinational. The controller never raises `mem_we` and `reg_we` in the same cycle.
- R5: With `load_sel` = 1, `wb_data` carries the RAM word at the first-operand address, and that word is what the destination register receives. With `load_sel` = 0, `wb_data` carries the ALU result.
- R6: Operation code 5'b10000 passes the second operand to the result unchanged, with V and C cleared.
- R7: Arithmetic codes wrap modulo 2^16: 5'b00010 gives A+B, 5'b00101 gives A+~B+1 (A−B), and 5'b00001 gives A+1.
- R8: Logic and shift codes are: 5'b01000 AND, 5'b01001 OR, 5'b01010 XOR, 5'b01011 NOT A, 5'b11000 shift A left by one, and 5'b10100 shift A right by one (logical). For all of these, V and C are 0.
- R9: `flag_n` is bit 15 of the ALU result and `flag_z` is 1 exactly when the ALU result is zero. Both follow the ALU result even while `load_sel` = 1.
- R10: For the three arithmetic codes, `flag_c` is the carry out of bit 15 of the sum (for subtract, 1 means no borrow), and `flag_v` is two's-complement overflow of that sum.
- R11: Any operation code not listed above passes the first operand through, with V and C cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, clears the register file |
| dst_sel | input | 3 | Destination register index |
| srca_sel | input | 3 | First read port index (also the memory address source) |
| srcb_sel | input | 3 | Second read port index |
| reg_we | input | 1 | Register write enable |
| imm_sel | input | 1 | 1 selects `imm` as second operand |
| load_sel | input | 1 | 1 writes back RAM data instead of ALU result |
| mem_we | input | 1 | RAM write enable |
| op_code | input | 5 | ALU operation code |
| imm | input | 16 | Immediate constant |
| wb_data | output | 16 | Write-back value of the current cycle |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the block with its default parameters: 16-bit words, 8 registers and 256 RAM words. At 16 bits the signed and unsigned wrap points (0x7FFF, 0x8000, 0xFFFF) can be reached with a single immediate. The 256-word depth lets a register holding 0x0142 show that only the low address byte selects a word. Eight registers leave room to hold an address, store data and loaded results at the same time, so the store and load paths can be checked against each other without overwriting live values.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
package dp_pkg;
  localparam logic [4:0] OP_INC   = 5'b00001;
  localparam logic [4:0] OP_ADD   = 5'b00010;
  localparam logic [4:0] OP_SUB   = 5'b00101;
  localparam logic [4:0] OP_AND   = 5'b01000;
  localparam logic [4:0] OP_OR    = 5'b01001;
  localparam logic [4:0] OP_XOR   = 5'b01010;
  localparam logic [4:0] OP_NOTA  = 5'b01011;
  localparam logic [4:0] OP_PASSB = 5'b10000;
  localparam logic [4:0] OP_SHR   = 5'b10100;
  localparam logic [4:0] OP_SHL   = 5'b11000;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } alu_flags_t;
endpackage

// File: rtl/dp_regfile.sv
`timescale 1ns/1ps
module dp_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int SEL_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  raddr_a,
  input  logic [SEL_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we) begin
      rf[waddr] <= wdata;
    end
  end

  assign rdata_a = rf[raddr_a];
  assign rdata_b = rf[raddr_b];

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    // R2: a selected write lands, any other register holds
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == SEL_W'(k)) |=> rf[k] == $past(wdata));
    assert_hold_unwritten_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && waddr == SEL_W'(k)) |=> $stable(rf[k]));
  end
endmodule

// File: rtl/dp_ram.sv
`timescale 1ns/1ps
module dp_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  // R4: stored word is present at its address after the edge
  assert_store_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(addr)] == $past(wdata));
endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output alu_flags_t        fl
);
  localparam int MSB = DATA_W - 1;

  logic              arith;
  logic [DATA_W-1:0] addend;
  logic              cin;
  logic [DATA_W:0]   sum;

  always_comb begin
    arith  = 1'b1;
    addend = b;
    cin    = 1'b0;
    case (op)
      OP_ADD: begin addend = b;  cin = 1'b0; end
      OP_SUB: begin addend = ~b; cin = 1'b1; end
      OP_INC: begin addend = '0; cin = 1'b1; end
      default: arith = 1'b0;
    endcase
    sum = {1'b0, a} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_INC: y = sum[MSB:0];
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_NOTA:  y = ~a;
      OP_SHL:   y = {a[MSB-1:0], 1'b0};
      OP_SHR:   y = {1'b0, a[MSB:1]};
      OP_PASSB: y = b;
      default:  y = a;
    endcase
    fl.n = y[MSB];
    fl.z = (y == '0);
    fl.c = arith & sum[DATA_W];
    fl.v = arith & (a[MSB] == addend[MSB]) & (sum[MSB] != a[MSB]);
  end

  always_comb begin
    // R6: pass-through of the second operand
    if (op == OP_PASSB) assert_passb_R6: assert (y == b && !fl.c && !fl.v);
    // R8: logic and shift codes never raise carry or overflow
    if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_NOTA ||
        op == OP_SHL || op == OP_SHR)
      assert_logic_noflags_R8: assert (!fl.c && !fl.v);
  end
endmodule

// File: rtl/cw_datapath.sv
`timescale 1ns/1ps
module cw_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NREG      = 8,
  parameter int MEM_WORDS = 256,
  parameter int SEL_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  dst_sel,
  input  logic [SEL_W-1:0]  srca_sel,
  input  logic [SEL_W-1:0]  srcb_sel,
  input  logic              reg_we,
  input  logic              imm_sel,
  input  logic              load_sel,
  input  logic              mem_we,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] imm,
  output logic [DATA_W-1:0] wb_data,
  output logic              flag_v,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_z
);
  localparam int AW = $clog2(MEM_WORDS);

  logic [DATA_W-1:0] bus_a, reg_b, bus_b, alu_y, ram_q;
  alu_flags_t        fl;

  dp_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(dst_sel), .wdata(wb_data),
    .raddr_a(srca_sel), .raddr_b(srcb_sel), .rdata_a(bus_a), .rdata_b(reg_b)
  );

  assign bus_b = imm_sel ? imm : reg_b;

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_code), .a(bus_a), .b(bus_b), .y(alu_y), .fl(fl)
  );

  dp_ram #(.DATA_W(DATA_W), .DEPTH(MEM_WORDS), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(bus_a[AW-1:0]),
    .wdata(bus_b), .rdata(ram_q)
  );

  assign wb_data = load_sel ? ram_q : alu_y;
  assign flag_v  = fl.v;
  assign flag_c  = fl.c;
  assign flag_n  = fl.n;
  assign flag_z  = fl.z;

  // R4: controller never writes both storage elements in one word
  assert_no_dual_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && mem_we));
endmodule

// File: tb/test_cw_datapath.sv
`timescale 1ns/1ps
module test_cw_datapath;
  import dp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] dst_sel = '0, srca_sel = '0, srcb_sel = '0;
  logic reg_we = 0, imm_sel = 0, load_sel = 0, mem_we = 0;
  logic [4:0] op_code = '0;
  logic [15:0] imm = '0;
  logic [15:0] wb_data;
  logic flag_v, flag_c, flag_n, flag_z;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cw_datapath i_cw_datapath (
    .clk(clk), .rst_n(rst_n), .dst_sel(dst_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .reg_we(reg_we), .imm_sel(imm_sel),
    .load_sel(load_sel), .mem_we(mem_we), .op_code(op_code), .imm(imm),
    .wb_data(wb_data), .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n),
    .flag_z(flag_z)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_fl(input string req, input logic ev, ec, en, ez);
    chk(req, {12'h0, flag_v, flag_c, flag_n, flag_z}, {12'h0, ev, ec, en, ez});
  endtask

  task automatic drive(input logic [2:0] d, a, b, input logic we, ib, ld, mw,
                       input logic [4:0] op, input logic [15:0] k);
    dst_sel = d; srca_sel = a; srcb_sel = b; reg_we = we; imm_sel = ib;
    load_sel = ld; mem_we = mw; op_code = op; imm = k;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, OP_OR, 16'h0);
  endtask

  task automatic load_imm(input logic [2:0] r, input logic [15:0] val);
    drive(r, 0, 0, 1, 1, 0, 0, OP_PASSB, val);
    @(negedge clk);
    idle();
  endtask

  task automatic read_reg(input logic [2:0] r, output logic [15:0] val);
    drive(0, r, 0, 0, 1, 0, 0, OP_OR, 16'h0);
    #1 val = wb_data;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    load_imm(1, 16'hAAAA);
    load_imm(5, 16'h5555);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      read_reg(3'(r), v);
      chk("R1 register cleared", v, 16'h0000);
    end
  endtask

  task automatic t_write_rules();
    logic [15:0] v;
    load_imm(1, 16'h1234);
    read_reg(1, v);
    chk("R6 constant loaded", v, 16'h1234);
    drive(2, 0, 0, 0, 1, 0, 0, OP_PASSB, 16'h0005);
    @(negedge clk);
    idle();
    read_reg(2, v);
    chk("R2 no write without enable", v, 16'h0000);
    load_imm(3, 16'h0007);
    drive(3, 3, 0, 1, 0, 0, 0, OP_INC, 16'h0);
    #1 chk("R2 same-cycle read sees old value", wb_data, 16'h0008);
    @(negedge clk);
    idle();
    read_reg(3, v);
    chk("R2 written on edge", v, 16'h0008);
  endtask

  task automatic t_bmux();
    load_imm(4, 16'h0F0F);
    load_imm(5, 16'h00FF);
    drive(0, 4, 5, 0, 0, 0, 0, OP_ADD, 16'h1000);
    #1 chk("R3 register operand B", wb_data, 16'h100E);
    @(negedge clk);
    drive(0, 4, 5, 0, 1, 0, 0, OP_ADD, 16'h1000);
    #1 chk("R3 immediate operand B", wb_data, 16'h1F0F);
    @(negedge clk);
    idle();
  endtask

  task automatic alu_case(input string req, input logic [15:0] av, bv,
                          input logic [4:0] op, input logic [15:0] ey,
                          input logic ev, ec, en, ez);
    load_imm(6, av);
    drive(0, 6, 0, 0, 1, 0, 0, op, bv);
    #1;
    chk(req, wb_data, ey);
    chk_fl({req, " flags"}, ev, ec, en, ez);
    @(negedge clk);
    idle();
  endtask

  task automatic t_arith();
    alu_case("R7 R10 add signed overflow", 16'h7FFF, 16'h0001, OP_ADD, 16'h8000, 1, 0, 1, 0);
    alu_case("R7 R10 add carry wrap", 16'hFFFF, 16'h0001, OP_ADD, 16'h0000, 0, 1, 0, 1);
    alu_case("R7 R10 sub equal", 16'h0005, 16'h0005, OP_SUB, 16'h0000, 0, 1, 0, 1);
    alu_case("R7 R10 sub borrow", 16'h0003, 16'h0005, OP_SUB, 16'hFFFE, 0, 0, 1, 0);
    alu_case("R7 R10 sub overflow", 16'h8000, 16'h0001, OP_SUB, 16'h7FFF, 1, 1, 0, 0);
    alu_case("R7 R10 inc wrap", 16'hFFFF, 16'h0000, OP_INC, 16'h0000, 0, 1, 0, 1);
    alu_case("R6 pass B zero", 16'h1234, 16'h0000, OP_PASSB, 16'h0000, 0, 0, 0, 1);
  endtask

  task automatic t_logic();
    alu_case("R8 R9 and", 16'hF0F0, 16'hFF00, OP_AND, 16'hF000, 0, 0, 1, 0);
    alu_case("R8 R9 or", 16'h0F00, 16'h00F0, OP_OR, 16'h0FF0, 0, 0, 0, 0);
    alu_case("R8 R9 xor zero", 16'hA5A5, 16'hA5A5, OP_XOR, 16'h0000, 0, 0, 0, 1);
    alu_case("R8 R9 not", 16'h00FF, 16'h0000, OP_NOTA, 16'hFF00, 0, 0, 1, 0);
    alu_case("R8 shift left", 16'h8001, 16'h0000, OP_SHL, 16'h0002, 0, 0, 0, 0);
    alu_case("R8 shift right", 16'h8001, 16'h0000, OP_SHR, 16'h4000, 0, 0, 0, 0);
    alu_case("R11 unlisted code", 16'h2468, 16'h1111, 5'b11111, 16'h2468, 0, 0, 0, 0);
  endtask

  task automatic t_mem();
    logic [15:0] v;
    load_imm(7, 16'h0042);
    load_imm(0, 16'h0000);
    load_imm(2, 16'h1357);
    drive(0, 7, 0, 0, 1, 0, 1, OP_ADD, 16'hBEEF);
    @(negedge clk);
    drive(0, 0, 2, 0, 0, 0, 1, OP_XOR, 16'h0);
    @(negedge clk);
    drive(1, 7, 0, 1, 1, 1, 0, OP_PASSB, 16'h0000);
    #1;
    chk("R5 load shows RAM word", wb_data, 16'hBEEF);
    chk_fl("R9 flags follow ALU during load", 0, 0, 0, 1);
    @(negedge clk);
    idle();
    read_reg(1, v);
    chk("R4 R5 constant stored and loaded", v, 16'hBEEF);
    drive(3, 0, 0, 1, 1, 1, 0, OP_OR, 16'h0);
    @(negedge clk);
    idle();
    read_reg(3, v);
    chk("R4 R5 register stored and loaded", v, 16'h1357);
    load_imm(6, 16'h0142);
    drive(0, 6, 0, 0, 1, 1, 0, OP_OR, 16'h0);
    #1 chk("R4 low address byte selects word", wb_data, 16'hBEEF);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_rules();
    t_bmux();
    t_arith();
    t_logic();
    t_mem();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule